// File: doc/BRIEF.md
# UART Automatic Power-Down Controller

This block decides when the transmit half and the receive half of one UART channel may stop their clocks. It does not gate clocks itself. It drives one clock-enable output for each half, and those outputs feed the clock-gating cells. The two halves sleep and wake independently.

The transmit half may sleep once its holding buffer and its shift register have both been empty for a full cycle. It wakes when the host writes to the holding buffer. The enable reasserts combinationally, so the edge that closes that write cycle already clocks the buffer.

The receive half may sleep once its FIFO has been empty and its receiver has been waiting for a start bit for a full cycle. It wakes on any level change of the serial input. That input is watched through a synchronizer running on the always-on clock.

A small register interface provides an automatic-mode enable, a forced power-down bit, a sleep status word and a sticky ring-indicator event. The ring-indicator event keeps working while either half is asleep.

Top module: `uart_pd_ctrl`

## Requirements
- R1: During reset and after its release, both clock enables are 1, `ri_irq` is 0, and registers 0 and 1 read 0.
- R2: While control bit 0 (auto enable, register 0) is 0 and control bit 1 (force) is 0, both clock enables stay 1 whatever the idle inputs do. A sleeping half wakes one cycle after the auto bit is cleared.
- R3: When control bit 1 (force, register 0) is 1, both clock enables are 0 from the cycle after the write, and a holding-buffer write does not raise `tx_clk_en`. Status register 1 then reads 3.
- R4: With auto mode on, `tx_clk_en` falls only at the second consecutive clock edge that samples `thr_empty` and `tsr_empty` both high. Any sample with either one low restarts the count.
- R5: With auto mode on, `rx_clk_en` falls only at the second consecutive clock edge that samples `rxf_empty` and `rx_idle` both high with no `rxd` edge pending. Any sample that breaks this restarts the count.
- R6: While the transmit half is asleep and not forced, `thr_wr` raises `tx_clk_en` in the same cycle. The half stays awake after `thr_wr` drops.
- R7: A level change on `rxd` wakes a sleeping receive half. `rx_clk_en` is still 0 after the second rising edge following the change and is 1 after the third.
- R8: A sleeping half does not wake because the other half's idle inputs go inactive. Only its own wake event wakes it.
- R9: A level change on `ri_n` sets event register 2 bit 0 and `ri_irq` after the third rising edge, also while both halves are forced down. Writing 1 to register 2 bit 0 clears it.
- R10: Status register 1 gives transmit asleep in bit 0 and receive asleep in bit 1. A half counts as asleep when forced or auto-slept. Register 0 reads back the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 event) |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 2 | Register read data, combinational from `reg_addr` |
| thr_wr | input | 1 | Host write into the transmit holding buffer |
| thr_empty | input | 1 | Transmit holding buffer empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rxf_empty | input | 1 | Receive FIFO empty |
| rx_idle | input | 1 | Receiver waiting for a start bit |
| rxd | input | 1 | Serial receive line, asynchronous |
| ri_n | input | 1 | Ring indicator, asynchronous |
| tx_clk_en | output | 1 | Transmit-half clock enable |
| rx_clk_en | output | 1 | Receive-half clock enable |
| ri_irq | output | 1 | Sticky ring-indicator event |

## Verification
The bench sends a one-cycle break in the idle condition just before the sleep point. A design that keeps no consecutive-idle count, or does not restart it, would gate a clock on that transient.

It watches `tx_clk_en` inside the cycle that carries `thr_wr`. A registered wake would lose the wake-up write to the holding buffer.

It counts edges after an `rxd` toggle and after an `ri_n` toggle. A missing or extra synchronizer stage would shift the wake or the event by a cycle.

It checks that forcing overrides a buffer write, and that a cleared auto bit returns both halves to running.

// File: rtl/uart_pd_pkg.sv
package uart_pd_pkg;

  localparam int ADDR_W = 2;
  localparam int REG_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_EVT  = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic force_pd;
    logic auto_en;
  } ctrl_t;

endpackage

// File: rtl/uart_pd_sync.sv
module uart_pd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic [STAGES-1:0] stg_q, stg_d;
  logic              prev_q, prev_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
    prev_d = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o = stg_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/uart_pd_domain.sv
module uart_pd_domain #(
  parameter int IDLE_CYC  = 1,
  parameter bit FAST_WAKE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic force_pd,
  input  logic idle,
  input  logic wake,
  output logic clk_en,
  output logic asleep
);

  localparam int                CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0]  LIM   = CNT_W'(IDLE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sleep_q, sleep_d;

  always_comb begin
    cnt_d   = cnt_q;
    sleep_d = sleep_q;
    if (!idle || wake) begin
      cnt_d = '0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (sleep_q) begin
      if (wake || !auto_en) sleep_d = 1'b0;
    end else if (auto_en && idle && !wake && (cnt_q == LIM)) begin
      sleep_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sleep_q <= sleep_d;
    end
  end

  generate
    if (FAST_WAKE) begin : g_fast
      assign clk_en = !force_pd && (!sleep_q || wake);
    end else begin : g_reg
      assign clk_en = !force_pd && !sleep_q;
    end
  endgenerate

  assign asleep = force_pd || sleep_q;

endmodule

// File: rtl/uart_pd_regs.sv
module uart_pd_regs
  import uart_pd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              ri_edge,
  input  logic              tx_asleep,
  input  logic              rx_asleep,
  output ctrl_t             ctrl,
  output logic              ri_event,
  output logic [REG_W-1:0]  rdata
);

  ctrl_t ctrl_q, ctrl_d;
  logic  evt_q, evt_d;

  always_comb begin
    ctrl_d = ctrl_q;
    evt_d  = evt_q;
    if (wr && (addr == A_CTRL)) begin
      ctrl_d.force_pd = wdata[1];
      ctrl_d.auto_en  = wdata[0];
    end
    if (ri_edge) begin
      evt_d = 1'b1;
    end else if (wr && (addr == A_EVT) && wdata[0]) begin
      evt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {ctrl_q.force_pd, ctrl_q.auto_en};
      A_STAT:  rdata = {rx_asleep, tx_asleep};
      A_EVT:   rdata = {1'b0, evt_q};
      default: rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign ri_event = evt_q;

endmodule

// File: rtl/uart_pd_ctrl.sv
module uart_pd_ctrl
  import uart_pd_pkg::*;
#(
  parameter int IDLE_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              thr_wr,
  input  logic              thr_empty,
  input  logic              tsr_empty,
  input  logic              rxf_empty,
  input  logic              rx_idle,
  input  logic              rxd,
  input  logic              ri_n,
  output logic              tx_clk_en,
  output logic              rx_clk_en,
  output logic              ri_irq
);

  localparam int N_DOM = 2;
  localparam int D_TX  = 0;
  localparam int D_RX  = 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic rxd_edge, ri_edge;

  uart_pd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_int_n), .din(rxd), .edge_o(rxd_edge)
  );

  uart_pd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ri_sync (
    .clk(clk), .rst_n(rst_int_n), .din(ri_n), .edge_o(ri_edge)
  );

  ctrl_t            ctrl_w;
  logic [N_DOM-1:0] idle_v, wake_v, en_v, asleep_v;

  assign idle_v[D_TX] = thr_empty && tsr_empty;
  assign wake_v[D_TX] = thr_wr;
  assign idle_v[D_RX] = rxf_empty && rx_idle;
  assign wake_v[D_RX] = rxd_edge;

  generate
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      uart_pd_domain #(
        .IDLE_CYC (IDLE_CYC),
        .FAST_WAKE(d == D_TX)
      ) u_dom (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .auto_en (ctrl_w.auto_en),
        .force_pd(ctrl_w.force_pd),
        .idle    (idle_v[d]),
        .wake    (wake_v[d]),
        .clk_en  (en_v[d]),
        .asleep  (asleep_v[d])
      );
    end
  endgenerate

  uart_pd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .ri_edge  (ri_edge),
    .tx_asleep(asleep_v[D_TX]),
    .rx_asleep(asleep_v[D_RX]),
    .ctrl     (ctrl_w),
    .ri_event (ri_irq),
    .rdata    (reg_rdata)
  );

  assign tx_clk_en = en_v[D_TX];
  assign rx_clk_en = en_v[D_RX];

endmodule

// File: rtl/uart_pd_ctrl_chk.sv
module uart_pd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_en,
  input logic force_pd,
  input logic thr_wr,
  input logic thr_empty,
  input logic tsr_empty,
  input logic rxf_empty,
  input logic rx_idle,
  input logic tx_clk_en,
  input logic rx_clk_en
);

  p_manual_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && $past(!auto_en) && !force_pd) |-> (tx_clk_en && rx_clk_en));

  p_force_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_pd |-> (!tx_clk_en && !rx_clk_en));

  p_tx_sleep_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_clk_en) && !force_pd && !$past(force_pd)) |-> $past(thr_empty && tsr_empty));

  p_rx_sleep_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_clk_en) && !force_pd && !$past(force_pd)) |-> $past(rxf_empty && rx_idle));

  p_tx_fast_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !force_pd) |-> tx_clk_en);

endmodule

bind uart_pd_ctrl uart_pd_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .auto_en  (ctrl_w.auto_en),
  .force_pd (ctrl_w.force_pd),
  .thr_wr   (thr_wr),
  .thr_empty(thr_empty),
  .tsr_empty(tsr_empty),
  .rxf_empty(rxf_empty),
  .rx_idle  (rx_idle),
  .tx_clk_en(tx_clk_en),
  .rx_clk_en(rx_clk_en)
);

// File: tb/uart_pd_ctrl_tb.sv
module uart_pd_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int NVEC  = 6;
  // [5] thr_empty [4] tsr_empty [3] rxf_empty [2] rx_idle [1] exp tx_en [0] exp rx_en
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110011, 6'b101111, 6'b110111, 6'b111101, 6'b011100, 6'b001000
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr, reg_wdata, reg_rdata;
  logic       thr_wr, thr_empty, tsr_empty, rxf_empty, rx_idle, rxd, ri_n;
  logic       tx_clk_en, rx_clk_en, ri_irq;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_pd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .thr_wr(thr_wr),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rxf_empty(rxf_empty),
    .rx_idle(rx_idle), .rxd(rxd), .ri_n(ri_n), .tx_clk_en(tx_clk_en),
    .rx_clk_en(rx_clk_en), .ri_irq(ri_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = 2'b00;
  endtask

  task automatic reg_read(input logic [1:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int rd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 2'd0;
    thr_wr = 1'b0; thr_empty = 1'b0; tsr_empty = 1'b0;
    rxf_empty = 1'b0; rx_idle = 1'b0; rxd = 1'b1; ri_n = 1'b1;
    tick(3);
    check("R1 tx_en in reset", tx_clk_en, 1);
    check("R1 rx_en in reset", rx_clk_en, 1);
    rst_n = 1'b1;
    tick(3);
    check("R1 ri_irq after reset", ri_irq, 0);
    reg_read(2'd0, rd); check("R1 ctrl after reset", rd, 0);
    reg_read(2'd1, rd); check("R1 status after reset", rd, 0);

    // R10 control readback, auto on
    reg_write(2'd0, 2'b01);
    reg_read(2'd0, rd); check("R10 ctrl readback", rd, 1);

    // R4 R5 R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      {thr_empty, tsr_empty, rxf_empty, rx_idle} = VEC[v][5:2];
      tick(1);
      check($sformatf("R4 tx_en row %0d", v), tx_clk_en, int'(VEC[v][1]));
      check($sformatf("R5 R8 rx_en row %0d", v), rx_clk_en, int'(VEC[v][0]));
    end
    reg_read(2'd1, rd); check("R10 status both asleep", rd, 3);

    // R6 transmit wakes in the write cycle
    thr_wr = 1'b1;
    #1;
    check("R6 tx_en same cycle as write", tx_clk_en, 1);
    tick(1);
    thr_wr = 1'b0;
    #1;
    check("R6 tx stays awake", tx_clk_en, 1);
    reg_read(2'd1, rd); check("R10 status rx only", rd, 2);

    // R7 receive wakes on rxd change
    rxd = 1'b0;
    tick(2);
    check("R7 rx_en after 2 edges", rx_clk_en, 0);
    tick(1);
    check("R7 rx_en after 3 edges", rx_clk_en, 1);

    // R3 forced power-down
    reg_write(2'd0, 2'b11);
    check("R3 tx_en forced", tx_clk_en, 0);
    check("R3 rx_en forced", rx_clk_en, 0);
    reg_read(2'd1, rd); check("R3 status forced", rd, 3);
    thr_wr = 1'b1;
    #1;
    check("R3 write does not wake when forced", tx_clk_en, 0);
    tick(1);
    thr_wr = 1'b0;

    // R9 ring indicator while forced down
    ri_n = 1'b0;
    tick(2);
    check("R9 ri_irq after 2 edges", ri_irq, 0);
    tick(1);
    check("R9 ri_irq after 3 edges", ri_irq, 1);
    reg_read(2'd2, rd); check("R9 event register", rd, 1);
    reg_write(2'd2, 2'b01);
    check("R9 ri_irq cleared", ri_irq, 0);

    // R2 manual mode keeps both halves running
    reg_write(2'd0, 2'b00);
    tick(1);
    thr_empty = 1'b1; tsr_empty = 1'b1; rxf_empty = 1'b1; rx_idle = 1'b1;
    tick(5);
    check("R2 tx_en manual idle", tx_clk_en, 1);
    check("R2 rx_en manual idle", rx_clk_en, 1);
    reg_read(2'd1, rd); check("R2 status manual", rd, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule